// File: doc/BRIEF.md
# Z80 ROM/RAM Paging Controller

This block sits beside a Z80 bus and turns each memory cycle into one active-low chip select for a shared ROM device, a low RAM bank or a high RAM bank. Two ROM images can be overlaid on the address map: one in the bottom 16 KiB window and one in the top 16 KiB window. Each overlay is switched on or off by a small paging register. The overlay affects reads only. A write to an overlaid address always reaches the RAM bank underneath, so a read and a write to the same address can hit different devices.

Software changes the paging register with an I/O write. The port decode is deliberately partial: only the two top address bits are compared. The byte is accepted as a paging command only when its top three bits carry the paging command code. The same command can also request a reset of an external interrupt counter. That request leaves the block as a single-cycle pulse. All outputs are registered: a bus state sampled at one rising clock edge shows up on the outputs just after that edge.

Top module: `mem_page_ctrl`

## Requirements
- R1: A paging write is taken from an I/O write (iorq_n=0, wr_n=0, m1_n=1) only when addr[15]=0 and addr[14]=1. No other address bit affects the decision.
- R2: An I/O write to the paging port updates the register only when wdata[7:5]=3'b100. Every other code leaves it unchanged.
- R3: In an accepted command, wdata[3]=1 disables the upper ROM and wdata[2]=1 disables the lower ROM. A value of 0 enables the corresponding ROM.
- R4: An accepted command with wdata[4]=1 drives int_clr_pulse high for exactly one cycle, in the cycle after the edge where the write was first sampled. This holds even if the write is held for several cycles.
- R5: The paging flags keep their value until the next accepted paging command. Memory cycles and rejected I/O writes do not change them.
- R6: A memory write (mreq_n=0, wr_n=0) selects RAM0 when addr[15]=0 and RAM1 when addr[15]=1, and never selects the ROM.
- R7: A memory read with addr[15:14]=2'b00 selects the ROM if the lower-ROM flag is 0, and RAM0 otherwise.
- R8: A memory read with addr[15:14]=2'b01 selects RAM0, and a read with addr[15:14]=2'b10 selects RAM1, whatever the flags hold.
- R9: A memory read with addr[15:14]=2'b11 selects the ROM if the upper-ROM flag is 0, and RAM1 otherwise.
- R10: rom_addr carries addr[14:0] of the sampled cycle with bit 15 forced to 0.
- R11: After a synchronous reset, all three selects are high, int_clr_pulse is 0 and both ROM flags are 0, so the first read of address 0x0000 selects the ROM.
- R12: An opcode fetch (m1_n=0, mreq_n=0, rd_n=0) decodes exactly like a read. No select is active when mreq_n=1, including interrupt acknowledge (m1_n=0, iorq_n=0).
- R13: At most one select is active in any cycle. Selects reflect the bus state sampled at the previous edge, and a paging command affects memory cycles sampled at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mreq_n | input | 1 | Memory request, active low |
| iorq_n | input | 1 | I/O request, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| addr | input | 16 | CPU address bus |
| wdata | input | 8 | CPU data bus during I/O writes |
| rom_sel_n | output | 1 | ROM chip select, active low, registered |
| ram0_sel_n | output | 1 | Low RAM bank select, active low, registered |
| ram1_sel_n | output | 1 | High RAM bank select, active low, registered |
| rom_addr | output | 16 | ROM device address with bit 15 cleared |
| int_clr_pulse | output | 1 | One-cycle interrupt-counter reset request |

## Verification
One paging command does two things at the same edge: it loads the ROM flags, and with bit 4 set it raises the interrupt-clear pulse. A read of an overlaid region can also follow that command on the very next edge. The bench provokes this by issuing a command with bit 4 set and, one cycle later, a read of 0x0000 or 0xC000. It then judges that the pulse appeared for exactly one cycle and that the read already used the new flag. A held I/O write checks separately that one command yields only one pulse.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

  typedef enum logic [1:0] {
    REG_LO  = 2'd0,
    REG_MID = 2'd1,
    REG_HI  = 2'd2,
    REG_TOP = 2'd3
  } region_e;

  typedef struct packed {
    logic       up_off;
    logic       lo_off;
    logic [1:0] vmode;
  } page_t;

  localparam int SEL_ROM  = 0;
  localparam int SEL_RAM0 = 1;
  localparam int SEL_RAM1 = 2;
  localparam int NSEL     = 3;

  localparam logic [2:0] CMD_PAGE = 3'b100;

endpackage

// File: rtl/mpc_port_decode.sv
module mpc_port_decode
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              load,
  output page_t             next_page,
  output logic              clr_req
);
  localparam int CMD_LSB = 5;
  localparam int CLR_BIT = 4;
  localparam int UP_BIT  = 3;
  localparam int LO_BIT  = 2;

  logic io_wr;
  logic port_hit;
  logic cmd_ok;
  logic qual;
  logic qual_q;

  assign io_wr    = !iorq_n && !wr_n && m1_n;
  assign port_hit = !addr[ADDR_W-1] && addr[ADDR_W-2];
  assign cmd_ok   = (wdata[CMD_LSB +: 3] == CMD_PAGE);
  assign qual     = io_wr && port_hit && cmd_ok;

  // Accept only the first sampled cycle of a qualified write.
  always_ff @(posedge clk) begin
    if (rst) qual_q <= 1'b0;
    else     qual_q <= qual;
  end

  assign load              = qual && !qual_q;
  assign clr_req           = load && wdata[CLR_BIT];
  assign next_page.up_off  = wdata[UP_BIT];
  assign next_page.lo_off  = wdata[LO_BIT];
  assign next_page.vmode   = wdata[1:0];

endmodule

// File: rtl/mpc_page_reg.sv
module mpc_page_reg
  import mpc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  load,
  input  page_t next_page,
  input  logic  clr_req,
  output page_t page,
  output logic  clr_pulse
);

  always_ff @(posedge clk) begin
    if (rst) begin
      page      <= '0;
      clr_pulse <= 1'b0;
    end else begin
      clr_pulse <= clr_req;
      if (load) page <= next_page;
    end
  end

endmodule

// File: rtl/mpc_sel_decode.sv
module mpc_sel_decode
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  page_t             page,
  output logic [NSEL-1:0]   sel_n,
  output logic [ADDR_W-1:0] rom_addr
);
  logic            mem_cyc;
  logic            is_wr;
  logic            is_rd;
  region_e         region;
  logic [NSEL-1:0] want;

  assign mem_cyc = !mreq_n && iorq_n;
  assign is_wr   = mem_cyc && !wr_n;
  assign is_rd   = mem_cyc && !rd_n && wr_n;
  assign region  = region_e'(addr[ADDR_W-1 -: 2]);

  always_comb begin
    want = '0;
    if (is_wr) begin
      if (addr[ADDR_W-1]) want[SEL_RAM1] = 1'b1;
      else                want[SEL_RAM0] = 1'b1;
    end else if (is_rd) begin
      unique case (region)
        REG_LO:  if (page.lo_off) want[SEL_RAM0] = 1'b1;
                 else             want[SEL_ROM]  = 1'b1;
        REG_MID: want[SEL_RAM0] = 1'b1;
        REG_HI:  want[SEL_RAM1] = 1'b1;
        REG_TOP: if (page.up_off) want[SEL_RAM1] = 1'b1;
                 else             want[SEL_ROM]  = 1'b1;
        default: want = '0;
      endcase
    end
  end

  for (genvar g = 0; g < NSEL; g++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) sel_n[g] <= 1'b1;
      else     sel_n[g] <= !want[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rom_addr <= '0;
    else     rom_addr <= {1'b0, addr[ADDR_W-2:0]};
  end

endmodule

// File: rtl/mem_page_ctrl.sv
module mem_page_ctrl
  import mpc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mreq_n,
  input  logic              iorq_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              m1_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rom_sel_n,
  output logic              ram0_sel_n,
  output logic              ram1_sel_n,
  output logic [ADDR_W-1:0] rom_addr,
  output logic              int_clr_pulse
);
  logic            load;
  logic            clr_req;
  page_t           next_page;
  page_t           page;
  logic [NSEL-1:0] sel_n;

  mpc_port_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .iorq_n(iorq_n), .wr_n(wr_n), .m1_n(m1_n),
    .addr(addr), .wdata(wdata), .load(load), .next_page(next_page),
    .clr_req(clr_req)
  );

  mpc_page_reg u_page (
    .clk(clk), .rst(rst), .load(load), .next_page(next_page),
    .clr_req(clr_req), .page(page), .clr_pulse(int_clr_pulse)
  );

  mpc_sel_decode #(.ADDR_W(ADDR_W)) u_sel (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .page(page), .sel_n(sel_n), .rom_addr(rom_addr)
  );

  assign rom_sel_n  = sel_n[SEL_ROM];
  assign ram0_sel_n = sel_n[SEL_RAM0];
  assign ram1_sel_n = sel_n[SEL_RAM1];

endmodule

// File: rtl/mem_page_ctrl_chk.sv
module mem_page_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mreq_n,
  input logic              iorq_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rom_sel_n,
  input logic              ram0_sel_n,
  input logic              ram1_sel_n,
  input logic [ADDR_W-1:0] rom_addr,
  input logic              int_clr_pulse,
  input logic [3:0]        page_bits
);

  // R13
  one_select_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({!rom_sel_n, !ram0_sel_n, !ram1_sel_n}) <= 1);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    int_clr_pulse |=> !int_clr_pulse);

  // R6
  write_no_rom_chk: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && iorq_n && !wr_n) |=> rom_sel_n);

  // R12
  idle_no_sel_chk: assert property (@(posedge clk) disable iff (rst)
    mreq_n |=> (rom_sel_n && ram0_sel_n && ram1_sel_n));

  // R10
  rom_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (!mreq_n && !rd_n) |=> (rom_addr == {1'b0, $past(addr[ADDR_W-2:0])}));

  // R5
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iorq_n || wr_n) |=> $stable(page_bits));

endmodule

bind mem_page_ctrl mem_page_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
  .wr_n(wr_n), .addr(addr), .rom_sel_n(rom_sel_n), .ram0_sel_n(ram0_sel_n),
  .ram1_sel_n(ram1_sel_n), .rom_addr(rom_addr), .int_clr_pulse(int_clr_pulse),
  .page_bits(page)
);

// File: tb/test_mem_page_ctrl.sv
`timescale 1ns/1ps
module test_mem_page_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mreq_n = 1'b1, iorq_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, m1_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rom_sel_n, ram0_sel_n, ram1_sel_n, int_clr_pulse;
  logic [15:0] rom_addr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mem_page_ctrl i_mem_page_ctrl (
    .clk(clk), .rst(rst), .mreq_n(mreq_n), .iorq_n(iorq_n), .rd_n(rd_n),
    .wr_n(wr_n), .m1_n(m1_n), .addr(addr), .wdata(wdata),
    .rom_sel_n(rom_sel_n), .ram0_sel_n(ram0_sel_n), .ram1_sel_n(ram1_sel_n),
    .rom_addr(rom_addr), .int_clr_pulse(int_clr_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    mreq_n = 1'b1; iorq_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; m1_n = 1'b1;
  endtask

  // active-high {rom, ram0, ram1}
  function automatic logic [2:0] sel_now();
    return {!rom_sel_n, !ram0_sel_n, !ram1_sel_n};
  endfunction

  function automatic logic [2:0] exp_sel(input int kind, input logic [15:0] a,
                                          input bit up, input bit lo);
    int reg_n = a[15:14];
    if (kind == 0) return a[15] ? 3'b001 : 3'b010;
    case (reg_n)
      0: return lo ? 3'b010 : 3'b100;
      1: return 3'b010;
      2: return 3'b001;
      default: return up ? 3'b001 : 3'b100;
    endcase
  endfunction

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    idle(); iorq_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    cyc();
    idle();
    cyc();
  endtask

  // kind: 0 write, 1 read, 2 opcode fetch
  task automatic mem_op(input int kind, input logic [15:0] a);
    idle(); mreq_n = 1'b0; addr = a;
    if (kind == 0) wr_n = 1'b0; else rd_n = 1'b0;
    if (kind == 2) m1_n = 1'b0;
    cyc();
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    rst = 1'b0;
    // R11 reset state
    chk("R11 selects idle", {29'd0, sel_now()}, 32'd0);
    chk("R11 pulse low", {31'd0, int_clr_pulse}, 32'd0);
    mem_op(1, 16'h0000);
    chk("R11 lower ROM on after reset", {29'd0, sel_now()}, 32'b100);

    // Exhaustive flag x region x kind sweep (R3 R6 R7 R8 R9 R10 R12)
    for (int fl = 0; fl < 4; fl++) begin
      io_wr(16'h7F00, {3'b100, 1'b0, fl[1], fl[0], 2'b00});
      chk("R3 no pulse without bit4", {31'd0, int_clr_pulse}, 32'd0);
      for (int rg = 0; rg < 4; rg++) begin
        for (int k = 0; k < 3; k++) begin
          logic [15:0] a;
          a = {rg[1:0], 14'(rg * 16'h1357 + k * 16'h0AB1)};
          mem_op(k, a);
          chk(k == 0 ? "R6 write select" : (rg == 0 ? "R7 low read" :
              (rg == 3 ? "R9 top read" : (k == 2 ? "R12 fetch" : "R8 mid read"))),
              {29'd0, sel_now()}, {29'd0, exp_sel(k, a, fl[1], fl[0])});
          chk("R10 rom address", {16'd0, rom_addr}, {16'd0, 1'b0, a[14:0]});
        end
      end
    end

    // R12 no select without MREQ, and during interrupt acknowledge
    idle(); rd_n = 1'b0; addr = 16'h0000; cyc();
    chk("R12 no mreq no select", {29'd0, sel_now()}, 32'd0);
    idle(); m1_n = 1'b0; iorq_n = 1'b0; addr = 16'hC000; cyc();
    chk("R12 int ack no select", {29'd0, sel_now()}, 32'd0);
    idle();

    // R1 port decode: both ROMs disabled, try to enable at each port prefix
    for (int p = 0; p < 4; p++) begin
      io_wr(16'h7F00, 8'b100_0_1100);
      io_wr({p[1:0], 14'h3FA5}, 8'b100_0_0000);
      mem_op(1, 16'h0000);
      chk("R1 port prefix decode", {29'd0, sel_now()},
          (p == 1) ? 32'b100 : 32'b010);
    end
    // R1 other address bits irrelevant
    io_wr(16'h7F00, 8'b100_0_1100);
    io_wr(16'h4000, 8'b100_0_0000);
    mem_op(1, 16'hC123);
    chk("R1 low bits ignored", {29'd0, sel_now()}, 32'b100);

    // R2 command code gate
    for (int c = 0; c < 8; c++) begin
      io_wr(16'h7F00, 8'b100_0_1100);
      io_wr(16'h7F00, {c[2:0], 1'b1, 4'b0000});
      mem_op(1, 16'h0000);
      chk("R2 command code", {29'd0, sel_now()}, (c == 4) ? 32'b100 : 32'b010);
    end

    // R5 memory traffic does not disturb flags
    io_wr(16'h7F00, 8'b100_0_0100);
    mem_op(0, 16'h0000); mem_op(0, 16'h7F00); mem_op(1, 16'h7F00);
    mem_op(1, 16'h0000);
    chk("R5 lower still off", {29'd0, sel_now()}, 32'b010);
    mem_op(1, 16'hC000);
    chk("R5 upper still on", {29'd0, sel_now()}, 32'b100);

    // R4 + R13: command with bit4, read on the following edge
    idle(); iorq_n = 1'b0; wr_n = 1'b0; addr = 16'h7F00; wdata = 8'b100_1_1000;
    cyc();
    chk("R4 pulse high", {31'd0, int_clr_pulse}, 32'd1);
    idle(); mreq_n = 1'b0; rd_n = 1'b0; addr = 16'hC000;
    cyc();
    chk("R4 pulse one cycle", {31'd0, int_clr_pulse}, 32'd0);
    chk("R13 next read sees new flags", {29'd0, sel_now()}, 32'b001);
    idle(); cyc();

    // R4 held write gives one pulse
    idle(); iorq_n = 1'b0; wr_n = 1'b0; addr = 16'h7F00; wdata = 8'b100_1_0000;
    cyc();
    chk("R4 held pulse first", {31'd0, int_clr_pulse}, 32'd1);
    cyc();
    chk("R4 held no second pulse", {31'd0, int_clr_pulse}, 32'd0);
    cyc();
    chk("R4 held still none", {31'd0, int_clr_pulse}, 32'd0);
    idle(); cyc();
    // R4 bit4 with wrong code: no pulse
    idle(); iorq_n = 1'b0; wr_n = 1'b0; addr = 16'h7F00; wdata = 8'b010_1_0000;
    cyc();
    chk("R4 rejected code no pulse", {31'd0, int_clr_pulse}, 32'd0);
    idle(); cyc();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule